// File: doc/BRIEF.md
# Idle Blanking-Start / Scrambler-Reset Swapper

This block produces the control-symbol pattern for a link framer while no video is being sent. On each symbol-clock strobe it emits one symbol code. After a programmable number of strobes it emits a blanking-start control symbol (BS); every other strobe carries idle fill. A BS can be replaced by a scrambler-reset symbol (SR) in two ways. The periodic path swaps one BS in every `bs_per_sr + 1` for an SR, and swaps every one when that value is zero. The wake path is armed by a one-shot `wake_go` pulse: it counts `wake_cnt` BS symbols and then turns the next control symbol into an SR exactly once. This lets a sleeping receiver resynchronise its descrambler quickly. Each SR also raises a one-cycle scrambler-reset pulse, which the downstream LFSR uses to reload its seed.

The wake path is a three-state machine. WK_IDLE has nothing pending. WK_COUNT counts BS symbols. WK_ARMED makes the next control symbol an SR. The transitions are as follows. `wake_go` moves any state to WK_COUNT, or to WK_ARMED when `wake_cnt` is 0, and clears the count. WK_COUNT moves to WK_ARMED when the BS count reaches `wake_cnt`. WK_ARMED moves back to WK_IDLE on the control symbol it forces to SR.

Top module: `idle_bs_sr_swapper`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_vld`, `out_sym`, `scr_rst` and `wake_busy` are all 0.
- R2: Across strobes, a control symbol (BS or SR) is emitted on every `max(ivl_cfg,1)`-th strobe and idle fill on the others. The first control symbol after reset comes on strobe number `max(ivl_cfg,1)`. Codes are `out_sym` = 2'b00 idle fill, 2'b01 BS, 2'b10 SR, and they are registered one cycle after the strobe edge with `out_vld` high.
- R3: With `bs_per_sr` = 0 and no wake request, every control symbol is SR.
- R4: With `bs_per_sr` = K > 0, control symbols follow the pattern K BS then one SR. The periodic count restarts from zero after every SR, whichever path produced it.
- R5: After `wake_go` with `wake_cnt` = N > 0, `wake_busy` rises. Once N further BS symbols have been emitted, the next control symbol is SR, and `wake_busy` falls on that same edge.
- R6: `wake_go` with `wake_cnt` = 0 makes the very next control symbol SR.
- R7: A `wake_go` while a wake is pending restarts the BS count from zero. A control symbol in the same cycle as `wake_go` is decided by the periodic rule only and is not counted.
- R8: `scr_rst` is high exactly in the cycles where `out_sym` is SR.
- R9: A cycle without `sym_en` advances no counter and leaves `out_vld` low and `out_sym` as idle fill in the following cycle.
- R10: An SR forced by the wake path also clears the periodic count, so the next periodic SR comes only after `bs_per_sr` further BS symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | Symbol-time strobe |
| ivl_cfg | input | IVL_W (16) | Strobes per control symbol (0 treated as 1) |
| bs_per_sr | input | BSC_W (9) | BS symbols between periodic SRs |
| wake_cnt | input | LDC_W (8) | BS symbols to count before the forced SR |
| wake_go | input | 1 | One-shot wake request |
| out_vld | output | 1 | Symbol code valid |
| out_sym | output | 2 | Emitted symbol code |
| scr_rst | output | 1 | Scrambler reset pulse |
| wake_busy | output | 1 | Wake request pending |

## Verification
Every output is one register stage away from the strobe edge that decides it. `out_sym`, `out_vld`, `scr_rst` and `wake_busy` therefore all show the result of a strobe one clock after it. The bench drives inputs on the falling edge. At each rising edge it advances a reference model built from the requirements using the inputs just applied, and then compares all four outputs one nanosecond later. Directed phases cover the zero interval, the zero swap count, a zero wake count and a restart in mid-count. A long constrained-random phase mixes strobe gaps, small intervals and wake requests.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    typedef enum logic [1:0] {
        SYM_FILL = 2'b00,
        SYM_BS   = 2'b01,
        SYM_SR   = 2'b10
    } sym_t;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'b00,
        WK_COUNT = 2'b01,
        WK_ARMED = 2'b10
    } wake_t;
endpackage

// File: rtl/bsr_interval.sv
module bsr_interval #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IVL_W-1:0] ivl,
    output logic             slot
);
    logic [IVL_W-1:0] icnt;
    logic [IVL_W-1:0] last_idx;

    // Zero interval behaves as one: every strobe is a control slot.
    always_comb begin
        last_idx = (ivl == '0) ? '0 : ivl - 1'b1;
        slot     = adv && (icnt >= last_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            icnt <= '0;
        else if (adv)
            icnt <= slot ? '0 : icnt + 1'b1;
    end

    // R9: no strobe, no progress
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(icnt));
endmodule

// File: rtl/bsr_period.sv
module bsr_period #(
    parameter int BSC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot,
    input  logic             force_sr,
    input  logic [BSC_W-1:0] bs_per_sr,
    output logic             is_sr
);
    logic [BSC_W-1:0] pcnt;

    always_comb is_sr = slot && (force_sr || (pcnt >= bs_per_sr));

    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (slot)
            pcnt <= is_sr ? '0 : pcnt + 1'b1;
    end

    // R4 / R10: any SR restarts the periodic count
    p_clear_after_sr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_sr |=> (pcnt == '0));
endmodule

// File: rtl/bsr_wake_fsm.sv
module bsr_wake_fsm
    import bsr_pkg::*;
#(
    parameter int LDC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             slot,
    input  logic             slot_sr,
    input  logic [LDC_W-1:0] load,
    output logic             force_sr,
    output logic             pending
);
    wake_t            st, st_n;
    logic [LDC_W-1:0] cnt, cnt_n, cnt_inc;

    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        cnt_inc = cnt + 1'b1;
        if (go) begin
            st_n  = (load == '0) ? WK_ARMED : WK_COUNT;
            cnt_n = '0;
        end else begin
            unique case (st)
                WK_IDLE: ;
                WK_COUNT: begin
                    if (slot && !slot_sr) begin
                        cnt_n = cnt_inc;
                        if (cnt_inc >= load)
                            st_n = WK_ARMED;
                    end
                end
                WK_ARMED: begin
                    if (slot)
                        st_n = WK_IDLE;
                end
                default: st_n = WK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= WK_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        force_sr = slot && !go && (st == WK_ARMED);
        pending  = (st != WK_IDLE);
    end

    // R7: a request always (re)starts from an empty count
    p_go_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (st != WK_IDLE) && (cnt == '0));
    // R5: armed state is left exactly on the forced slot
    p_armed_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WK_ARMED && slot && !go) |=> (st == WK_IDLE));
endmodule

// File: rtl/idle_bs_sr_swapper.sv
module idle_bs_sr_swapper
    import bsr_pkg::*;
#(
    parameter int IVL_W = 16,
    parameter int BSC_W = 9,
    parameter int LDC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_en,
    input  logic [IVL_W-1:0] ivl_cfg,
    input  logic [BSC_W-1:0] bs_per_sr,
    input  logic [LDC_W-1:0] wake_cnt,
    input  logic             wake_go,
    output logic             out_vld,
    output logic [1:0]       out_sym,
    output logic             scr_rst,
    output logic             wake_busy
);
    logic slot, force_sr, is_sr;
    sym_t sym_d;

    bsr_interval #(.IVL_W(IVL_W)) u_ivl (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (sym_en),
        .ivl  (ivl_cfg),
        .slot (slot)
    );

    bsr_period #(.BSC_W(BSC_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot),
        .force_sr (force_sr),
        .bs_per_sr(bs_per_sr),
        .is_sr    (is_sr)
    );

    bsr_wake_fsm #(.LDC_W(LDC_W)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (wake_go),
        .slot    (slot),
        .slot_sr (is_sr),
        .load    (wake_cnt),
        .force_sr(force_sr),
        .pending (wake_busy)
    );

    always_comb begin
        if (!slot)
            sym_d = SYM_FILL;
        else if (is_sr)
            sym_d = SYM_SR;
        else
            sym_d = SYM_BS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_sym <= SYM_FILL;
            scr_rst <= 1'b0;
        end else begin
            out_vld <= sym_en;
            out_sym <= sym_d;
            scr_rst <= slot && is_sr;
        end
    end

    // R9: quiet cycles carry idle fill
    p_fill_when_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_sym == SYM_FILL));
    // R8: reset pulse only alongside SR
    p_pulse_with_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scr_rst |-> (out_sym == SYM_SR) && out_vld);
    // R5: pending clears only on the edge that emits the forced SR
    p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_busy) |-> scr_rst);
endmodule

// File: tb/idle_bs_sr_swapper_bench.sv
`timescale 1ns/1ps
module idle_bs_sr_swapper_bench;
    localparam int IVL_W = 16;
    localparam int BSC_W = 9;
    localparam int LDC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sym_en = 1'b0;
    logic [IVL_W-1:0] ivl_cfg = 16'd4;
    logic [BSC_W-1:0] bs_per_sr = 9'd2;
    logic [LDC_W-1:0] wake_cnt = 8'd5;
    logic             wake_go = 1'b0;
    logic             out_vld;
    logic [1:0]       out_sym;
    logic             scr_rst;
    logic             wake_busy;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_icnt = 0, m_pcnt = 0, m_fc = 0, m_st = 0;
    int e_vld = 0, e_sym = 0, e_rst = 0;

    always #4 clk = ~clk;

    idle_bs_sr_swapper #(.IVL_W(IVL_W), .BSC_W(BSC_W), .LDC_W(LDC_W)) u_idle_bs_sr_swapper (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .ivl_cfg(ivl_cfg),
        .bs_per_sr(bs_per_sr), .wake_cnt(wake_cnt), .wake_go(wake_go),
        .out_vld(out_vld), .out_sym(out_sym), .scr_rst(scr_rst), .wake_busy(wake_busy)
    );

    function automatic int last_of(input int ivl);
        return (ivl == 0) ? 0 : ivl - 1;
    endfunction

    task automatic model_edge(input bit en, input bit go);
        bit ctrl, forced, sr;
        ctrl   = en && (m_icnt >= last_of(int'(ivl_cfg)));
        forced = ctrl && !go && (m_st == 2);
        sr     = ctrl && (forced || (m_pcnt >= int'(bs_per_sr)));
        if (en) m_icnt = ctrl ? 0 : m_icnt + 1;
        if (ctrl) m_pcnt = sr ? 0 : m_pcnt + 1;
        if (go) begin
            m_st = (wake_cnt == 0) ? 2 : 1;
            m_fc = 0;
        end else if (m_st == 1 && ctrl && !sr) begin
            m_fc = m_fc + 1;
            if (m_fc >= int'(wake_cnt)) m_st = 2;
        end else if (m_st == 2 && ctrl) begin
            m_st = 0;
        end
        e_vld = en;
        e_sym = !ctrl ? 0 : (sr ? 2 : 1);
        e_rst = sr;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (out_vld !== e_vld[0] || out_sym !== e_sym[1:0] || scr_rst !== e_rst[0]
            || wake_busy !== (m_st != 0)) begin
            errors++;
            $display("FAIL %s: vld/sym/rst/busy = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     tag, out_vld, out_sym, scr_rst, wake_busy, e_vld, e_sym, e_rst, (m_st != 0));
        end
    endtask

    task automatic step(input bit en, input bit go, input string tag);
        @(negedge clk);
        sym_en  = en;
        wake_go = go;
        @(posedge clk);
        model_edge(en, go);
        #1;
        compare(tag);
    endtask

    task automatic cfg(input int ivl, input int bsc, input int lc);
        @(negedge clk);
        sym_en = 1'b0; wake_go = 1'b0;
        ivl_cfg = ivl[IVL_W-1:0]; bs_per_sr = bsc[BSC_W-1:0]; wake_cnt = lc[LDC_W-1:0];
        @(posedge clk);
        model_edge(1'b0, 1'b0);
        #1;
        compare("R9");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_vld !== 1'b0 || out_sym !== 2'b00 || scr_rst !== 1'b0 || wake_busy !== 1'b0) begin
            errors++;
            $display("FAIL R1: outputs %0d/%0d/%0d/%0d expected 0/0/0/0", out_vld, out_sym, scr_rst, wake_busy);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare("R1");

        // R2 / R4: interval 4, swap every third control symbol
        cfg(4, 2, 5);
        for (int i = 0; i < 48; i++) step(1'b1, 1'b0, "R2");
        // R9: gaps in the strobe
        for (int i = 0; i < 20; i++) step(i[0], 1'b0, "R9");
        // R3: zero swap count, every control is SR (R8 pulse alongside)
        cfg(3, 0, 5);
        for (int i = 0; i < 24; i++) step(1'b1, 1'b0, "R3");
        // R2: zero interval behaves as one
        cfg(0, 3, 5);
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, "R8");
        // R5: wake after 5 BS with a long periodic count
        cfg(2, 511, 5);
        step(1'b1, 1'b1, "R5");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R5");
        // R10: periodic count restarted by forced SR
        cfg(2, 3, 2);
        step(1'b0, 1'b1, "R10");
        for (int i = 0; i < 24; i++) step(1'b1, 1'b0, "R10");
        // R6: zero wake count
        cfg(3, 511, 0);
        step(1'b0, 1'b1, "R6");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R6");
        // R7: restart in mid-count, and start on a control slot
        cfg(2, 511, 4);
        step(1'b1, 1'b1, "R7");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R7");
        step(1'b1, 1'b1, "R7");
        for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R7");
        // compliance-style interval
        cfg(252, 0, 5);
        for (int i = 0; i < 600; i++) step(1'b1, 1'b0, "R3");
        // constrained random
        for (int blk = 0; blk < 30; blk++) begin
            cfg(int'($urandom_range(0, 6)), int'($urandom_range(0, 5)), int'($urandom_range(0, 4)));
            for (int i = 0; i < 200; i++)
                step(($urandom_range(0, 3) != 0), ($urandom_range(0, 40) == 0), "R4");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule